// File: doc/BRIEF.md
# Lock-Aware Fixed-Priority Arbiter

This block chooses one winner among N requesters each time the shared resource becomes free. Every requester has a fixed priority number, set at build time; the lowest number is the most important. When the `advance` input is high, the block evaluates the pending requests and registers a one-hot grant. Requesters that lose keep their request asserted and compete again at the next `advance` cycle.

A requester may raise its lock bit together with its request. The lock has no effect on the arbitration that grants the requester. If that requester wins and requests again in the very next `advance` cycle, it wins that cycle too, ahead of every other requester, including a more important one that also holds its lock bit. A request marked as part of a locked burst that is already running always wins.

Priority numbers must be unique among requesters that can be active together. If two active requesters share a priority number, the block issues no grant in that cycle and raises an error flag. The flag stays set until reset.

Top module: `lock_prio_arb`

## Requirements
- R1: While reset is high and on the first cycle after reset, `grant` is all zeros and `error` is 0.
- R2: Requester i has priority number PRIOS[i*PW +: PW]. With no burst or held lock in play, an `advance` cycle grants the requesting index with the lowest number.
- R3: A request whose `burst` bit is set wins over all other requests. If several such requests are present, the one with the lowest number wins.
- R4: Suppose the winner of an `advance` cycle had its `lock` bit or `burst` bit set. If that requester requests again in the next `advance` cycle, it wins that cycle, even against a more important requester that also has its lock bit set.
- R5: If the holder of a lock does not request in the next `advance` cycle, the lock lapses. Selection then returns to R2.
- R6: A set `lock` bit does not change the selection in which that requester competes for the first time.
- R7: `grant` changes only on the clock edge that ends an `advance` cycle, and it is visible from the next cycle. While `advance` is low, `grant` and the lock state hold their values. `grant` never names a requester that was not requesting in the `advance` cycle.
- R8: An `advance` cycle with no requests gives an all-zero `grant` and clears any held lock.
- R9: An `advance` cycle in which two active requesters share a priority number sets `error`, gives an all-zero `grant` and clears any held lock.
- R10: `error` stays at 1 until reset, and arbitration carries on in later cycles.
- R11: `grant` is always one-hot or all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Previous transfer complete; arbitrate this cycle |
| req | input | N | Request bit per requester |
| lock | input | N | Reserve the grant for the requester's next immediate request |
| burst | input | N | Request belongs to a locked burst in progress |
| grant | output | N | Registered one-hot grant |
| error | output | 1 | Sticky priority-collision flag |

## Verification
The hardest case to reach is a held lock meeting a more important requester in the very next `advance` cycle. A stall cycle with `advance` low must not break the lock, and a missing request must make it lapse. Directed sequences set up a winner with its lock bit, then present competing requests with and without the holder. Some of these sequences put a low-`advance` cycle in between. A random phase then mixes lock bits, sparse burst bits and `advance` stalls so that these orderings occur many more times. A second instance is built with a repeated priority number so that collisions can occur at all. It is driven to show that the error flag stays set, that no grant is issued in the collision cycle, and that a held lock is cleared.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Which rule decided the winner of an arbitration cycle
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_BURST = 2'd1,
        SRC_HOLD  = 2'd2,
        SRC_PRIO  = 2'd3
    } sel_src_e;

    localparam int unsigned DEF_N  = 4;
    localparam int unsigned DEF_PW = 4;

endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned PW = 4,
    parameter logic [N*PW-1:0] PRIOS = '0
) (
    input  logic [N-1:0] mask,
    output logic [N-1:0] pick,
    output logic         any
);
    logic [PW-1:0] best;
    logic          found;

    always_comb begin
        pick  = '0;
        best  = '0;
        found = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            if (mask[i] && (!found || PRIOS[i*PW +: PW] < best)) begin
                pick     = '0;
                pick[i]  = 1'b1;
                best     = PRIOS[i*PW +: PW];
                found    = 1'b1;
            end
        end
        any = found;
    end
endmodule

// File: rtl/clash_det.sv
module clash_det #(
    parameter int unsigned N  = 4,
    parameter int unsigned PW = 4,
    parameter logic [N*PW-1:0] PRIOS = '0
) (
    input  logic [N-1:0] req,
    output logic         clash
);
    localparam int unsigned PAIRS = N * N;
    logic [PAIRS-1:0] pair_hit;

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            if (j > i && PRIOS[i*PW +: PW] == PRIOS[j*PW +: PW]) begin : g_same
                assign pair_hit[i*N + j] = req[i] & req[j];
            end else begin : g_diff
                assign pair_hit[i*N + j] = 1'b0;
            end
        end
    end

    assign clash = |pair_hit;
endmodule

// File: rtl/lock_hold.sv
module lock_hold #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd,
    input  logic         set_vld,
    input  logic [N-1:0] set_oh,
    output logic         hold_vld,
    output logic [N-1:0] hold_oh
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld <= 1'b0;
            hold_oh  <= '0;
        end else if (upd) begin
            hold_vld <= set_vld;
            hold_oh  <= set_vld ? set_oh : '0;
        end
    end
endmodule

// File: rtl/lock_prio_arb.sv
module lock_prio_arb
    import arb_pkg::*;
#(
    parameter int unsigned N  = DEF_N,
    parameter int unsigned PW = DEF_PW,
    parameter logic [N*PW-1:0] PRIOS = {4'd3, 4'd7, 4'd2, 4'd5}
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic [N-1:0] req,
    input  logic [N-1:0] lock,
    input  logic [N-1:0] burst,
    output logic [N-1:0] grant,
    output logic         error
);
    logic [N-1:0] burst_req;
    logic [N-1:0] burst_pick, plain_pick;
    logic         burst_any, plain_any;
    logic         clash;
    logic         hold_vld;
    logic [N-1:0] hold_oh;
    logic         hold_hit;
    sel_src_e     src;
    logic [N-1:0] win;
    logic         win_keep;
    logic         hold_set;
    logic [N-1:0] grant_q;
    logic         error_q;

    assign burst_req = req & burst;

    prio_pick #(.N(N), .PW(PW), .PRIOS(PRIOS)) u_pick_burst (
        .mask(burst_req), .pick(burst_pick), .any(burst_any)
    );

    prio_pick #(.N(N), .PW(PW), .PRIOS(PRIOS)) u_pick_plain (
        .mask(req), .pick(plain_pick), .any(plain_any)
    );

    clash_det #(.N(N), .PW(PW), .PRIOS(PRIOS)) u_clash (
        .req(req), .clash(clash)
    );

    assign hold_hit = hold_vld && ((hold_oh & req) != '0);

    always_comb begin
        if (!plain_any || clash) begin
            src = SRC_NONE;
            win = '0;
        end else if (burst_any) begin
            src = SRC_BURST;
            win = burst_pick;
        end else if (hold_hit) begin
            src = SRC_HOLD;
            win = hold_oh;
        end else begin
            src = SRC_PRIO;
            win = plain_pick;
        end
        win_keep = (win & (lock | burst)) != '0;
        hold_set = (src != SRC_NONE) && win_keep;
    end

    lock_hold #(.N(N)) u_hold (
        .clk(clk), .rst(rst), .upd(advance),
        .set_vld(hold_set), .set_oh(win),
        .hold_vld(hold_vld), .hold_oh(hold_oh)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            error_q <= 1'b0;
        end else if (advance) begin
            grant_q <= win;
            if (clash) error_q <= 1'b1;
        end
    end

    assign grant = grant_q;
    assign error = error_q;
endmodule

// File: rtl/lock_prio_arb_chk.sv
module lock_prio_arb_chk #(
    parameter int unsigned N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         advance,
    input logic [N-1:0] req,
    input logic [N-1:0] grant,
    input logic         error
);
    // R11
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R10
    error_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        error |=> error);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(grant));

    // R7
    grant_requested_chk: assert property (@(posedge clk) disable iff (rst)
        advance |=> ((grant & ~$past(req)) == '0));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && req == '0) |=> (grant == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (grant == '0 && !error));
endmodule

bind lock_prio_arb lock_prio_arb_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .advance(advance),
    .req(req), .grant(grant), .error(error)
);

// File: tb/lock_prio_arb_tb.sv
`timescale 1ns/1ps
module lock_prio_arb_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // Instance A: unique priorities 5,2,7,3 for indices 0..3
    logic       adv_a = 1'b0;
    logic [3:0] req_a = '0, lock_a = '0, burst_a = '0;
    logic [3:0] grant_a;
    logic       err_a;

    lock_prio_arb #(.N(4), .PW(4), .PRIOS({4'd3, 4'd7, 4'd2, 4'd5})) dut_i (
        .clk(clk), .rst(rst), .advance(adv_a), .req(req_a), .lock(lock_a),
        .burst(burst_a), .grant(grant_a), .error(err_a)
    );

    // Instance B: priorities 2,4,2 for indices 0..2 (0 and 2 collide)
    logic       adv_b = 1'b0;
    logic [2:0] req_b = '0, lock_b = '0, burst_b = '0;
    logic [2:0] grant_b;
    logic       err_b;

    lock_prio_arb #(.N(3), .PW(4), .PRIOS({4'd2, 4'd4, 4'd2})) dut_dup_i (
        .clk(clk), .rst(rst), .advance(adv_b), .req(req_b), .lock(lock_b),
        .burst(burst_b), .grant(grant_b), .error(err_b)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state for instance A
    int unsigned PR [4] = '{5, 2, 7, 3};
    logic [3:0] m_gnt = '0;
    logic       m_hv  = 1'b0;
    int         m_hi  = 0;

    function automatic int low_pick(logic [3:0] m);
        int w = -1;
        for (int i = 0; i < 4; i++)
            if (m[i] && (w < 0 || PR[i] < PR[w])) w = i;
        return w;
    endfunction

    task automatic model(logic [3:0] r, logic [3:0] l, logic [3:0] b, logic a);
        int w;
        if (!a) return;
        if (r == '0) begin
            m_gnt = '0; m_hv = 1'b0;
            return;
        end
        if ((r & b) != '0)        w = low_pick(r & b);
        else if (m_hv && r[m_hi]) w = m_hi;
        else                      w = low_pick(r);
        m_gnt = '0; m_gnt[w] = 1'b1;
        m_hv = l[w] | b[w];
        m_hi = w;
    endtask

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Called at a negedge: drive, one edge, sample at next negedge
    task automatic step_a(string tag, logic a, logic [3:0] r, logic [3:0] l, logic [3:0] b);
        adv_a = a; req_a = r; lock_a = l; burst_a = b;
        model(r, l, b, a);
        @(posedge clk); @(negedge clk);
        check(tag, grant_a, m_gnt);
        check({tag, " error"}, {3'b0, err_a}, 4'b0);
    endtask

    task automatic step_b(string tag, logic [2:0] r, logic [2:0] l,
                          logic [2:0] eg, logic ee);
        adv_b = 1'b1; req_b = r; lock_b = l; burst_b = '0;
        @(posedge clk); @(negedge clk);
        check(tag, {1'b0, grant_b}, {1'b0, eg});
        check({tag, " error"}, {3'b0, err_b}, {3'b0, ee});
    endtask

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        // R1: during reset
        check("R1 grant in reset", grant_a, 4'b0);
        check("R1 error in reset", {3'b0, err_a}, 4'b0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 grant after reset", grant_a, 4'b0);
        check("R1 error after reset", {3'b0, err_b}, 4'b0);

        // R2: plain priority
        step_a("R2 all request", 1, 4'b1111, 4'b0, 4'b0);
        step_a("R2 without best", 1, 4'b1101, 4'b0, 4'b0);
        step_a("R2 two low", 1, 4'b0101, 4'b0, 4'b0);
        // R6: lock on a first selection does not help
        step_a("R6 lock first", 1, 4'b1011, 4'b0001, 4'b0);
        // R4: holder wins next cycle against more important locked one
        step_a("R4 take lock", 1, 4'b0001, 4'b0001, 4'b0);
        step_a("R4 holder keeps", 1, 4'b0011, 4'b0010, 4'b0);
        step_a("R4 lapsed after unlocked win", 1, 4'b0011, 4'b0, 4'b0);
        // R4 with a stall in between; R7 stall holds grant
        step_a("R4 take lock 2", 1, 4'b0100, 4'b0100, 4'b0);
        step_a("R7 stall holds", 0, 4'b1010, 4'b0, 4'b0);
        step_a("R4 holder after stall", 1, 4'b1110, 4'b0, 4'b0);
        // R5: holder absent, lock lapses
        step_a("R5 take lock", 1, 4'b0100, 4'b0100, 4'b0);
        step_a("R5 holder absent", 1, 4'b1000, 4'b0, 4'b0);
        step_a("R5 lapsed", 1, 4'b0110, 4'b0, 4'b0);
        // R3: burst requests win
        step_a("R3 burst single", 1, 4'b1111, 4'b0, 4'b0100);
        step_a("R3 burst pair", 1, 4'b1111, 4'b0, 4'b0101);
        step_a("R3 burst over holder", 1, 4'b1101, 4'b0, 4'b1000);
        // R8: idle clears grant and lock
        step_a("R8 take lock", 1, 4'b0001, 4'b0001, 4'b0);
        step_a("R8 idle zero", 1, 4'b0000, 4'b0, 4'b0);
        step_a("R8 lock cleared", 1, 4'b0011, 4'b0, 4'b0);
        // R7: non-requesters are never granted, stall keeps grant
        step_a("R7 stall with new req", 0, 4'b0010, 4'b0, 4'b0);

        // R9/R10 on the instance with a repeated priority number
        step_b("R2 dup inst no clash", 3'b011, 3'b000, 3'b001, 1'b0);
        step_b("R9 take lock", 3'b010, 3'b010, 3'b010, 1'b0);
        step_b("R9 clash", 3'b111, 3'b000, 3'b000, 1'b1);
        step_b("R9 lock cleared", 3'b011, 3'b000, 3'b001, 1'b1);
        step_b("R10 sticky", 3'b010, 3'b000, 3'b010, 1'b1);
        step_b("R10 sticky idle", 3'b000, 3'b000, 3'b000, 1'b1);

        // Random phase on instance A
        for (int k = 0; k < 600; k++) begin
            logic [3:0] r, l, b;
            logic a;
            r = 4'($urandom());
            l = 4'($urandom()) & 4'($urandom());
            b = '0;
            for (int i = 0; i < 4; i++) if ($urandom() % 10 == 0) b[i] = 1'b1;
            a = ($urandom() % 4) != 0;
            step_a("R2 R4 R5 random", a, r, l, b);
        end

        // R1: reset clears sticky error
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1 error cleared by reset", {3'b0, err_b}, 4'b0);
        done = 1'b1;
    end

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule